// File: doc/BRIEF.md
# External Bus Access-State Controller

This block times each external bus cycle from a small set of per-area configuration registers. The address space is divided into eight areas. A requester presents an access with a 3-bit area number and a flag that says whether the target is external or on-chip. The controller then runs the access for a computed number of bus states. While the access runs, `busy` is high. `strobe` is high for external accesses, and `done` pulses in the last state.

Three 8-bit registers set the timing: one access-state register and two wait-control registers (high and low), reached through a simple select/write/read port. The access-state register has one bit per area. A 0 in that bit gives a 2-state cycle with no program waits. A 1 gives a 3-state cycle, followed by the programmed wait states for that area. On-chip accesses always take 2 states, whatever the registers hold. A hardware standby input forces the registers back to their reset value. A software standby input freezes them.

Top module: `busStateCtl`

## Requirements
- R1: After reset, all three registers read 0xFF. Register select code 0 reads the access-state register, code 1 the high wait register, code 2 the low wait register, and code 3 reads 0x00.
- R2: While `hwStandby` is high, all three registers are forced to 0xFF and any access in progress is abandoned. `busy` is low from the next cycle.
- R3: While `swStandby` is high, register writes are ignored and the register contents are kept. No new access is accepted.
- R4: A write with `regWrEn` high updates the register named by `regSel` at the clock edge. A write to code 3 changes nothing.
- R5: An access with `reqExternal` low lasts exactly 2 states with `strobe` low, for any register contents.
- R6: An external access to area n lasts exactly 2 states when bit n of the access-state register is 0, whatever the wait fields hold.
- R7: An external access to area n lasts 3+w states when bit n is 1. Here w is the 2-bit wait field of area n, taken from bits [2n+1:2n] of the 16-bit value {high wait register, low wait register}. Areas 7..4 therefore sit in the high register, from its top bits downward.
- R8: During an access, `busy` is high for every state and `strobe` equals the external flag in every state. `done` is high for exactly one cycle, in the final state, and `busy` is low in the cycle after it.
- R9: A request is accepted only when `reqValid` is high while the block is idle. The first state is the cycle after the accepting edge. Requests raised while busy are ignored.
- R10: An access takes its timing from the register values held before its accepting edge. A write made while an access is in progress affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwStandby | input | 1 | Hardware standby: reinitialises registers, aborts access |
| swStandby | input | 1 | Software standby: freezes registers, blocks new accesses |
| regSel | input | 2 | Register select (0 access-state, 1 wait high, 2 wait low) |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for the selected register |
| reqValid | input | 1 | Access request |
| reqArea | input | 3 | Area number of the request |
| reqExternal | input | 1 | 1 for external space, 0 for on-chip |
| busy | output | 1 | High during every state of an access |
| strobe | output | 1 | External bus strobe |
| done | output | 1 | One-cycle pulse in the final state |

## Verification
A wrong latched length or area decode shows up at the ports as a `busy` window of the wrong size. It also moves `done` away from the last state. Both are visible within at most six cycles of the accepting edge. A stale or corrupted register shows in `regRdData` in the same cycle it is selected. It also changes the length of the next access to that area. The sweep covers every area, both settings of the access-state bit, every wait value and both spaces, so a mis-wired field position cannot hide.

// File: rtl/busStatePkg.sv
package busStatePkg;
  localparam int AREAS   = 8;
  localparam int DW      = 8;
  localparam int WBITS   = 2;
  localparam int AREA_W  = $clog2(AREAS);
  localparam int SHORT_ST = 2;
  localparam int LONG_ST  = 3;
  localparam int INT_ST   = 2;
  localparam int MAX_LEN  = LONG_ST + (1 << WBITS) - 1;
  localparam int LEN_W    = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {
    SEL_AST  = 2'd0,
    SEL_WHI  = 2'd1,
    SEL_WLO  = 2'd2,
    SEL_NONE = 2'd3
  } regSelT;

  typedef struct packed {
    logic startAcc;
    logic stepAcc;
  } accStrobeT;
endpackage

// File: rtl/busStateDp.sv
module busStateDp
  import busStatePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqExternal,
  input  accStrobeT         ctl,
  output logic              lastState,
  output logic              extLatched
);
  localparam logic [DW-1:0] INIT = '1;

  logic [DW-1:0]      astReg, waitHiReg, waitLoReg;
  logic [2*DW-1:0]    waitAll;
  logic [WBITS-1:0]   waitOf [AREAS];
  logic [LEN_W-1:0]   lenNext, lenReg, cnt;

  assign waitAll = {waitHiReg, waitLoReg};

  for (genvar a = 0; a < AREAS; a++) begin : g_wait
    assign waitOf[a] = waitAll[a*WBITS +: WBITS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      astReg    <= INIT;
      waitHiReg <= INIT;
      waitLoReg <= INIT;
    end else if (hwStandby) begin
      astReg    <= INIT;
      waitHiReg <= INIT;
      waitLoReg <= INIT;
    end else if (regWrEn && !swStandby) begin
      case (regSel)
        SEL_AST: astReg    <= regWrData;
        SEL_WHI: waitHiReg <= regWrData;
        SEL_WLO: waitLoReg <= regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regSel)
      SEL_AST: regRdData = astReg;
      SEL_WHI: regRdData = waitHiReg;
      SEL_WLO: regRdData = waitLoReg;
      default: regRdData = '0;
    endcase
  end

  always_comb begin
    if (!reqExternal)
      lenNext = LEN_W'(INT_ST);
    else if (astReg[reqArea])
      lenNext = LEN_W'(LONG_ST) + LEN_W'(waitOf[reqArea]);
    else
      lenNext = LEN_W'(SHORT_ST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg     <= '0;
      cnt        <= '0;
      extLatched <= 1'b0;
    end else if (ctl.startAcc) begin
      lenReg     <= lenNext;
      cnt        <= LEN_W'(1);
      extLatched <= reqExternal;
    end else if (ctl.stepAcc) begin
      cnt <= cnt + LEN_W'(1);
    end
  end

  assign lastState = (cnt == lenReg);
endmodule

// File: rtl/busStateCtl.sv
module busStateCtlFsm
  import busStatePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hwStandby,
  input  logic      swStandby,
  input  logic      reqValid,
  input  logic      lastState,
  output accStrobeT ctl,
  output logic      active,
  output logic      finish
);
  typedef enum logic {IDLE, RUN} fsmT;
  fsmT state, stateNext;

  assign active = (state == RUN);
  assign finish = active && lastState;

  always_comb begin
    ctl.startAcc = (state == IDLE) && reqValid && !hwStandby && !swStandby;
    ctl.stepAcc  = active && !lastState && !hwStandby;
    stateNext    = state;
    if (hwStandby)        stateNext = IDLE;
    else if (ctl.startAcc) stateNext = RUN;
    else if (finish)       stateNext = IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNext;
  end
endmodule

module busStateCtl
  import busStatePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  input  logic              reqValid,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqExternal,
  output logic              busy,
  output logic              strobe,
  output logic              done
);
  accStrobeT ctl;
  logic lastState, extLatched, active, finish;

  busStateCtlFsm i_fsm (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
    .reqValid(reqValid), .lastState(lastState), .ctl(ctl),
    .active(active), .finish(finish)
  );

  busStateDp i_dp (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .reqArea(reqArea), .reqExternal(reqExternal),
    .ctl(ctl), .lastState(lastState), .extLatched(extLatched)
  );

  assign busy   = active;
  assign strobe = active && extLatched;
  assign done   = finish;
endmodule

// File: rtl/busStateCtl_chk.sv
module busStateCtl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hwStandby,
  input logic       swStandby,
  input logic [1:0] regSel,
  input logic [7:0] regRdData,
  input logic       busy,
  input logic       strobe,
  input logic       done
);
  // R2
  hw_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (regSel == 2'd3 || regRdData == 8'hFF));
  // R2
  hw_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> !busy);
  // R3
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swStandby && !hwStandby) |=> (!$stable(regSel) || $stable(regRdData)));
  // R3
  sw_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && swStandby) |=> !busy);
  // R8
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> busy);
  // R8
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R8
  done_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R6
  min_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !done);
  // R5
  int_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !strobe && !hwStandby) |=> done);
endmodule

bind busStateCtl busStateCtl_chk i_chk (
  .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
  .regSel(regSel), .regRdData(regRdData), .busy(busy),
  .strobe(strobe), .done(done)
);

// File: tb/test_busStateCtl.sv
module test_busStateCtl;
  logic clk = 0, rstN = 0, hwStandby = 0, swStandby = 0;
  logic [1:0] regSel = 0;
  logic regWrEn = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic reqValid = 0, reqExternal = 0;
  logic [2:0] reqArea = 0;
  logic busy, strobe, done;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  busStateCtl i_busStateCtl (.*);

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] s, logic [7:0] d);
    @(negedge clk); regSel = s; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rdCheck(string req, logic [1:0] s, logic [7:0] exp);
    @(negedge clk); regSel = s; #1;
    check(req, regRdData, exp);
  endtask

  // Launch an access, then measure busy length, done count/position, strobe.
  task automatic runAcc(input logic [2:0] a, input logic ext,
                        output int len, output int doneCnt,
                        output int doneAt, output int strBad);
    @(negedge clk); reqValid = 1; reqArea = a; reqExternal = ext;
    @(negedge clk); reqValid = 0;
    len = 0; doneCnt = 0; doneAt = 0; strBad = 0;
    while (busy && len < 20) begin
      len++;
      if (strobe != ext) strBad++;
      if (done) begin doneCnt++; doneAt = len; end
      @(negedge clk);
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int len, dc, da, sb, expLen, wf;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset values and select codes
    rdCheck("R1", 2'd0, 8'hFF);
    rdCheck("R1", 2'd1, 8'hFF);
    rdCheck("R1", 2'd2, 8'hFF);
    rdCheck("R1", 2'd3, 8'h00);
    check("R1 busy", busy, 0);

    // R4 writes, code 3 ignored
    wrReg(2'd0, 8'hA5); wrReg(2'd1, 8'h3C); wrReg(2'd2, 8'h96);
    wrReg(2'd3, 8'h00);
    rdCheck("R4", 2'd0, 8'hA5);
    rdCheck("R4", 2'd1, 8'h3C);
    rdCheck("R4", 2'd2, 8'h96);
    rdCheck("R4", 2'd3, 8'h00);

    // R5 R6 R7 R8 sweep: every area, ast bit, wait value, space
    for (int a = 0; a < 8; a++) begin
      for (int ab = 0; ab < 2; ab++) begin
        for (int w = 0; w < 4; w++) begin
          logic [15:0] wv;
          wv = 16'h0000;
          wv[a*2 +: 2] = w[1:0];
          wv = wv | (16'h4924 & ~(16'h3 << (a*2)));
          wrReg(2'd0, ab ? (8'h1 << a) : ~(8'h1 << a));
          wrReg(2'd1, wv[15:8]);
          wrReg(2'd2, wv[7:0]);
          for (int e = 0; e < 2; e++) begin
            runAcc(a[2:0], e[0], len, dc, da, sb);
            wf = w;
            if (e == 0) expLen = 2;
            else if (ab == 1) expLen = 3 + wf;
            else expLen = 2;
            check(e == 0 ? "R5 len" : (ab == 1 ? "R7 len" : "R6 len"), len, expLen);
            check("R8 done count", dc, 1);
            check("R8 done position", da, expLen);
            check("R8 strobe", sb, 0);
          end
        end
      end
    end

    // R10 write during access affects only later access
    wrReg(2'd0, 8'h01); wrReg(2'd2, 8'h03);
    @(negedge clk); reqValid = 1; reqArea = 0; reqExternal = 1;
    @(negedge clk); reqValid = 0;
    @(negedge clk); regSel = 2'd2; regWrData = 8'h00; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
    len = 2;
    while (busy && len < 20) begin len++; @(negedge clk); end
    check("R10 in-progress", len, 6);
    runAcc(3'd0, 1'b1, len, dc, da, sb);
    check("R10 next access", len, 3);

    // R10 write on accepting edge uses old value
    @(negedge clk); reqValid = 1; reqArea = 0; reqExternal = 1;
    regSel = 2'd2; regWrData = 8'h02; regWrEn = 1;
    @(negedge clk); reqValid = 0; regWrEn = 0;
    len = 0;
    while (busy && len < 20) begin len++; @(negedge clk); end
    check("R10 same edge", len, 3);
    runAcc(3'd0, 1'b1, len, dc, da, sb);
    check("R10 after same edge", len, 5);

    // R9 request while busy ignored
    @(negedge clk); reqValid = 1; reqArea = 0; reqExternal = 1;
    @(negedge clk); reqValid = 0;
    @(negedge clk); reqValid = 1;
    @(negedge clk); reqValid = 0;
    while (busy) @(negedge clk);
    check("R9 no restart", busy, 0);
    @(negedge clk);
    check("R9 still idle", busy, 0);

    // R3 software standby
    @(negedge clk); swStandby = 1;
    wrReg(2'd0, 8'h55);
    rdCheck("R3 hold", 2'd0, 8'h01);
    @(negedge clk); reqValid = 1; reqExternal = 0;
    @(negedge clk); reqValid = 0;
    check("R3 no start", busy, 0);
    swStandby = 0;

    // R2 hardware standby aborts and reinitialises
    wrReg(2'd1, 8'h00);
    @(negedge clk); reqValid = 1; reqArea = 0; reqExternal = 1;
    @(negedge clk); reqValid = 0; hwStandby = 1;
    @(negedge clk); hwStandby = 0;
    check("R2 abort", busy, 0);
    rdCheck("R2 init", 2'd0, 8'hFF);
    rdCheck("R2 init", 2'd1, 8'hFF);
    rdCheck("R2 init", 2'd2, 8'hFF);
    runAcc(3'd6, 1'b1, len, dc, da, sb);
    check("R2 R7 after init", len, 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule